// File: doc/BRIEF.md
# Pipelined Integer Square Root

This block takes an unsigned radicand of 2N bits and returns its integer square root (N bits) together with the remainder (N+1 bits). The radicand is consumed two bits at a time, most significant pair first. Each pair is handled by one row of bit cells, and a register stage follows each row. A row subtracts the partial root with binary 01 appended from the running remainder, with the new pair shifted in below it. The borrow out of the row's top cell decides the root bit. The same bit then selects either the difference or the unchanged operand as the next remainder, so no add-back step is needed.

The pipeline takes a new radicand on every clock and has no stall. Each result leaves N cycles after its input, in input order, marked by a valid flag. The valid bits clear on an asynchronous active-low reset. The data registers are not reset and carry no meaning while their valid bit is low.

Top module: `isqrt_pipe`

## Requirements
- R1: When `out_valid_o` is high, `root_o` equals the largest integer r with r·r ≤ the radicand that produced the result.
- R2: When `out_valid_o` is high, `rem_o` equals radicand − root², which never exceeds 2·root and therefore fits in N+1 bits.
- R3: A radicand presented with `in_valid_i` high on a rising edge appears on the outputs, with `out_valid_o` high, exactly N rising edges later.
- R4: A new radicand is accepted on every consecutive clock, and the results come out back to back in the same order.
- R5: An edge where `in_valid_i` is low produces a cycle with `out_valid_o` low N edges later. The output valid flag never rises without a matching input.
- R6: While `rst_ni` is low, `out_valid_o` is low. After release it stays low until new inputs have passed through all N stages, even if the pipeline was full when reset was asserted.
- R7: Radicand 0 gives root 0 and remainder 0. The all-ones radicand gives root 2^N−1 and remainder 2·(2^N−1).
- R8: In each row the root bit is 1 exactly when the operand {remainder, pair} is at least {partial root, 01}. When the bit is 1 the remainder becomes the difference, and when it is 0 the operand passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Radicand is valid this cycle |
| radicand_i | input | 2N | Unsigned radicand |
| out_valid_o | output | 1 | Result is valid this cycle |
| root_o | output | N | Integer square root |
| rem_o | output | N+1 | Remainder, radicand − root² |

## Verification
On every cycle, the assertions check each row's borrow decision against a plain magnitude comparison of its operands. They also check that a row's incoming remainder fits the width the next row expects, that every valid output has a remainder no larger than twice its root, and that the number of results in flight never exceeds N and never goes negative. The exact root and remainder of each radicand, the N-cycle latency, the ordering of back-to-back results, the bubbles left by idle inputs, and the flushing of a full pipeline by reset can only be shown by the bench. It sweeps every radicand and compares each against an arithmetic reference.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;
  // width of the per-row subtract datapath
  function automatic int row_w(input int n);
    return n + 2;
  endfunction

  // width of the remainder (max 2*root)
  function automatic int rem_w(input int n);
    return n + 1;
  endfunction
endpackage

// File: rtl/isqrt_csm_cell.sv
module isqrt_csm_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic b_i,
  input  logic u_i,
  output logic d_o,
  output logic bo_o
);
  logic diff;

  assign diff = x_i ^ y_i ^ b_i;
  assign bo_o = (~x_i & y_i) | (~x_i & b_i) | (y_i & b_i);
  assign d_o  = u_i ? diff : x_i;
endmodule

// File: rtl/isqrt_row.sv
module isqrt_row #(
  parameter int N = 4
) (
  input  logic                            valid_i,
  input  logic [isqrt_pkg::rem_w(N)-1:0]  rem_i,
  input  logic [1:0]                      pair_i,
  input  logic [N-1:0]                    root_i,
  output logic [isqrt_pkg::rem_w(N)-1:0]  rem_o,
  output logic                            bit_o
);
  localparam int W  = isqrt_pkg::row_w(N);
  localparam int RW = isqrt_pkg::rem_w(N);

  logic [W-1:0] x;
  logic [W-1:0] y;
  logic [W-1:0] d;
  logic [W:0]   bc;
  logic         u;

  // remainder top bit is always 0 at a row input
  assign x     = {rem_i[RW-2:0], pair_i};
  assign y     = {root_i, 2'b01};
  assign bc[0] = 1'b0;
  assign u     = ~bc[W];

  for (genvar i = 0; i < W; i++) begin : g_cell
    isqrt_csm_cell u_cell (
      .x_i (x[i]),
      .y_i (y[i]),
      .b_i (bc[i]),
      .u_i (u),
      .d_o (d[i]),
      .bo_o(bc[i+1])
    );
  end

  assign rem_o = d[RW-1:0];
  assign bit_o = u;

  always_comb begin
    if (valid_i) begin
      // R8
      borrow_decision_chk: assert (bit_o == (x >= y));
      // R2
      rem_fits_chk: assert (rem_i[RW-1] == 1'b0);
    end
  end
endmodule

// File: rtl/isqrt_pipe.sv
module isqrt_pipe #(
  parameter int N = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  input  logic [2*N-1:0]      radicand_i,
  output logic                out_valid_o,
  output logic [N-1:0]        root_o,
  output logic [N:0]          rem_o
);
  localparam int RW = isqrt_pkg::rem_w(N);
  localparam int DW = 2 * N;
  localparam int CW = $clog2(N + 2) + 1;

  logic [N:0]            vld_s;
  logic [N:0][RW-1:0]    rem_s;
  logic [N:0][N-1:0]     root_s;
  logic [N:0][DW-1:0]    rad_s;

  assign vld_s[0]  = in_valid_i;
  assign rem_s[0]  = '0;
  assign root_s[0] = '0;
  assign rad_s[0]  = radicand_i;

  for (genvar k = 0; k < N; k++) begin : g_stage
    logic [RW-1:0] rem_n;
    logic          bit_n;

    isqrt_row #(.N(N)) u_row (
      .valid_i(vld_s[k]),
      .rem_i  (rem_s[k]),
      .pair_i (rad_s[k][DW-1 -: 2]),
      .root_i (root_s[k]),
      .rem_o  (rem_n),
      .bit_o  (bit_n)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vld_s[k+1] <= 1'b0;
      else         vld_s[k+1] <= vld_s[k];
    end

    always_ff @(posedge clk_i) begin
      rem_s[k+1]  <= rem_n;
      root_s[k+1] <= {root_s[k][N-2:0], bit_n};
      rad_s[k+1]  <= rad_s[k] << 2;
    end
  end

  assign out_valid_o = vld_s[N];
  assign root_o      = root_s[N];
  assign rem_o       = rem_s[N];

  // results in flight, counted from the ports
  logic [CW-1:0] inflight_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight_q <= '0;
    else         inflight_q <= inflight_q + CW'(in_valid_i) - CW'(out_valid_o);
  end

  // R3
  inflight_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= CW'(N));

  // R5
  no_orphan_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> inflight_q != '0);

  // R2
  rem_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ({1'b0, rem_o} <= {1'b0, root_o, 1'b0}));

  // R6
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !out_valid_o);
endmodule

// File: tb/sim_isqrt_pipe.sv
`timescale 1ns/1ps
module sim_isqrt_pipe;
  localparam int N  = 4;
  localparam int DW = 2 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] radicand = '0;
  logic          out_valid;
  logic [N-1:0]  root;
  logic [N:0]    rem;

  int total = 0;
  int bad   = 0;
  logic          hv [N];
  logic [DW-1:0] hr [N];

  always #4 clk = ~clk;

  isqrt_pipe #(.N(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .radicand_i(radicand),
    .out_valid_o(out_valid), .root_o(root), .rem_o(rem)
  );

  function automatic int ref_root(input int x);
    int r = 0;
    while ((r + 1) * (r + 1) <= x) r++;
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < N; i++) begin hv[i] = 1'b0; hr[i] = '0; end
  endtask

  // drive at negedge, clock in, check at next negedge
  task automatic cyc(input logic v, input logic [DW-1:0] r);
    in_valid = v;
    radicand = r;
    @(posedge clk);
    for (int i = N - 1; i > 0; i--) begin hv[i] = hv[i-1]; hr[i] = hr[i-1]; end
    hv[0] = v; hr[0] = r;
    @(negedge clk);
    if (hv[N-1]) begin
      int x  = int'(hr[N-1]);
      int er = ref_root(x);
      chk("R3 valid", int'(out_valid), 1);
      if (x == 0 || x == (1 << DW) - 1) begin
        chk("R7 root", int'(root), er);
        chk("R7 rem", int'(rem), x - er * er);
      end else begin
        chk("R1 root", int'(root), er);
        chk("R2 R8 rem", int'(rem), x - er * er);
      end
    end else begin
      chk("R5 bubble", int'(out_valid), 0);
    end
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_hist();
    repeat (3) @(negedge clk);
    chk("R6 reset", int'(out_valid), 0);
    rst_n = 1'b1;
    // R4 R1 R2: every radicand, back to back
    for (int x = 0; x < (1 << DW); x++) cyc(1'b1, DW'(x));
    for (int i = 0; i < N; i++) cyc(1'b0, '0);
    // R5: alternating and sparse gaps, descending values
    for (int x = (1 << DW) - 1; x >= 0; x -= 3) cyc((x % 2) == 0, DW'(x));
    for (int i = 0; i < N; i++) cyc(1'b0, '0);
    // R7 corners repeated
    cyc(1'b1, '0); cyc(1'b1, '1); cyc(1'b1, '0); cyc(1'b1, '1);
    for (int i = 0; i < N; i++) cyc(1'b0, '0);
    // R6: reset with a full pipeline
    for (int i = 0; i < N; i++) begin
      in_valid = 1'b1; radicand = DW'(i * 37 + 5);
      @(posedge clk);
    end
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    #1;
    chk("R6 reset flush", int'(out_valid), 0);
    @(negedge clk);
    chk("R6 reset hold", int'(out_valid), 0);
    rst_n = 1'b1;
    clear_hist();
    for (int i = 0; i < N + 2; i++) cyc(1'b0, '0);
    for (int x = 200; x < 232; x++) cyc(1'b1, DW'(x));
    for (int i = 0; i < N; i++) cyc(1'b0, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule